// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between an interrupt source layer and a single processor core. It holds one pending slot (a source number and the priority it arrived with) together with the priority the processor is currently running at. It drives a single interrupt line to the core. Requests arrive from sources as (source number, priority) pairs. Each request is either taken into the slot, possibly displacing the request held there, or refused. Every refused or displaced request is handed back to its source as a reject strobe, so the source can replay it later. Whenever the slot falls empty after a priority change or an end-of-interrupt, a resend strobe tells the source layer to replay what it holds.

Software reaches the presenter through five register operations. Accept is a destructive read. Poll is a read with no side effects. The other three are a processor-priority write, a write of the priority for the inter-processor interrupt (IPI), and an end-of-interrupt write. The IPI is produced inside the presenter under a fixed source number and competes for the slot like any external request. Priorities use the rule that a smaller number wins, and the all-ones value means "none". The presentation word carries the processor priority in its top byte and the pending source in its low 24 bits.

Top module: `irq_presenter`

## Requirements
- R1: After reset the interrupt line is low, all strobes are low, the presentation word is 0 and the IPI priority is 0xFF (no IPI).
- R2: The presentation word returned by reads is {processor priority[31:24], pending source[23:0]}, and a source field of 0 means the slot is empty.
- R3: With no operation in the same cycle, a request is refused if its priority is not strictly below the processor priority, or if the slot holds a request whose priority is equal or lower in value. A refused request gives rej_b_valid with its source one cycle later and changes no state.
- R4: A request that is not refused loads its source and priority into the slot and raises irq_out. A request it displaces, if that request came from an external source, is returned on rej_a one cycle later.
- R5: Accept (op_code 0) returns the presentation word and the IPI priority on rd_valid one cycle later. It lowers irq_out, moves the pending priority into the processor priority, clears the source field and sets the pending priority to 0xFF.
- R6: Poll (op_code 1) returns the presentation word and the IPI priority one cycle later and changes nothing.
- R7: A processor-priority write (op_code 2, value in op_wdata[7:0]) below the current value sets the new value. If the slot is occupied at a pending priority not below the new value, it empties the slot, lowers irq_out and rejects an external occupant on rej_a.
- R8: A processor-priority write at or above the current value, when the slot is empty, pulses resend_req. If the IPI priority is below the new value, the IPI is also loaded into the slot.
- R9: An IPI-priority write (op_code 3, value in op_wdata[7:0]) stores the value. If the value is below the processor priority and the slot holds nothing at an equal or lower value, the IPI (source 2) is loaded at that priority and irq_out rises, and an external occupant is rejected on rej_a.
- R10: An end-of-interrupt (op_code 4) copies op_wdata[31:24] into the processor priority and pulses eoi_valid with op_wdata[23:0] one cycle later. If the slot is empty it also pulses resend_req, and it first loads the IPI when the IPI priority is below the new processor priority.
- R11: A request arriving in the same cycle as any register operation is refused on rej_b and has no effect on the slot.
- R12: The IPI is never returned on rej_a when it is displaced or cleared. Sources must use neither number 0 nor number 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Source request present this cycle |
| req_src | input | 24 | Requesting source number |
| req_prio | input | 8 | Priority of the request |
| op_valid | input | 1 | Register operation this cycle |
| op_code | input | 3 | 0 accept, 1 poll, 2 processor priority, 3 IPI priority, 4 end-of-interrupt |
| op_wdata | input | 32 | Write data of the operation |
| irq_out | output | 1 | Interrupt line to the core |
| rd_valid | output | 1 | Read data valid strobe |
| rd_data | output | 32 | Presentation word read |
| rd_ipi | output | 8 | IPI priority read |
| rej_a_valid | output | 1 | Displaced/cleared occupant reject strobe |
| rej_a_src | output | 24 | Source of the rej_a strobe |
| rej_b_valid | output | 1 | Refused incoming request strobe |
| rej_b_src | output | 24 | Source of the rej_b strobe |
| eoi_valid | output | 1 | End-of-interrupt forward strobe |
| eoi_src | output | 24 | Source number being completed |
| resend_req | output | 1 | Ask the source layer to replay |

## Verification
The assertions check the local cause-and-effect rules on every cycle. A refused low-priority request always bounces on rej_b, and so does a colliding request. Accept always lowers the line. Poll never moves the line or emits strobes. End-of-interrupt always forwards its source. rej_a never carries 0 or the IPI number. The preemption chains can only be shown by the bench's scenarios against its reference model. Examples are a request displacing another, the IPI displaced without a reject, a priority write emptying the slot, and end-of-interrupt reloading the IPI. The same holds for the exact read words after a sequence of operations.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
  typedef enum logic [2:0] {
    OP_ACCEPT   = 3'd0,
    OP_POLL     = 3'd1,
    OP_SET_PRIO = 3'd2,
    OP_SET_IPI  = 3'd3,
    OP_EOI      = 3'd4
  } ipr_op_e;
endpackage

// File: rtl/ipr_slot_cmp.sv
// Decides whether a candidate priority may take the pending slot.
module ipr_slot_cmp #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              pend_busy,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] cand_prio,
  output logic              wins
);
  logic beats_cpu;
  logic blocked;

  always_comb begin
    beats_cpu = cand_prio < cur_prio;
    blocked   = pend_busy && (pend_prio <= cand_prio);
    wins      = beats_cpu && !blocked;
  end
endmodule

// File: rtl/ipr_strobe_reg.sv
// One-cycle strobe with a payload that loads only when the strobe fires.
module ipr_strobe_reg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_d,
  input  logic [W-1:0] data_d,
  output logic         v_q,
  output logic [W-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      data_q <= '0;
    end else begin
      v_q <= v_d;
      if (v_d) data_q <= data_d;
    end
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import ipr_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [SRC_W-1:0]          req_src,
  input  logic [PRIO_W-1:0]         req_prio,
  input  logic                      op_valid,
  input  logic [2:0]                op_code,
  input  logic [SRC_W+PRIO_W-1:0]   op_wdata,
  output logic                      irq_out,
  output logic                      rd_valid,
  output logic [SRC_W+PRIO_W-1:0]   rd_data,
  output logic [PRIO_W-1:0]         rd_ipi,
  output logic                      rej_a_valid,
  output logic [SRC_W-1:0]          rej_a_src,
  output logic                      rej_b_valid,
  output logic [SRC_W-1:0]          rej_b_src,
  output logic                      eoi_valid,
  output logic [SRC_W-1:0]          eoi_src,
  output logic                      resend_req
);
  localparam int REG_W = SRC_W + PRIO_W;
  localparam int RD_W  = REG_W + PRIO_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

  // state registers
  logic [PRIO_W-1:0] cppr_q, cppr_d;
  logic [SRC_W-1:0]  xisr_q, xisr_d;
  logic [PRIO_W-1:0] pprio_q, pprio_d;
  logic [PRIO_W-1:0] mfrr_q, mfrr_d;
  logic              ipi_q, ipi_d;
  logic              irq_q, irq_d;
  logic              resend_q, resend_d;

  // strobe next values
  logic              rej_a_v_d, rej_b_v_d, eoi_v_d, rd_v_d;
  logic [SRC_W-1:0]  rej_a_s_d, rej_b_s_d, eoi_s_d;
  logic [RD_W-1:0]   rd_d, rd_q;

  ipr_op_e           op_e;
  logic              pend_busy;
  logic [PRIO_W-1:0] w_lo, w_hi, rs_prio;
  logic              req_wins, ipi_wr_wins, ipi_rs_wins;

  assign op_e      = ipr_op_e'(op_code);
  assign pend_busy = (xisr_q != '0);
  assign w_lo      = op_wdata[PRIO_W-1:0];
  assign w_hi      = op_wdata[REG_W-1 -: PRIO_W];
  assign rs_prio   = (op_e == OP_EOI) ? w_hi : w_lo;

  ipr_slot_cmp #(.PRIO_W(PRIO_W)) u_req_cmp (
    .cur_prio(cppr_q), .pend_busy(pend_busy), .pend_prio(pprio_q),
    .cand_prio(req_prio), .wins(req_wins));

  ipr_slot_cmp #(.PRIO_W(PRIO_W)) u_ipi_wr_cmp (
    .cur_prio(cppr_q), .pend_busy(pend_busy), .pend_prio(pprio_q),
    .cand_prio(w_lo), .wins(ipi_wr_wins));

  // replay path: slot is known empty when it is used
  ipr_slot_cmp #(.PRIO_W(PRIO_W)) u_ipi_rs_cmp (
    .cur_prio(rs_prio), .pend_busy(1'b0), .pend_prio(PRIO_NONE),
    .cand_prio(mfrr_q), .wins(ipi_rs_wins));

  always_comb begin
    cppr_d = cppr_q; xisr_d = xisr_q; pprio_d = pprio_q; mfrr_d = mfrr_q;
    ipi_d = ipi_q; irq_d = irq_q; resend_d = 1'b0;
    rej_a_v_d = 1'b0; rej_a_s_d = xisr_q;
    rej_b_v_d = 1'b0; rej_b_s_d = req_src;
    eoi_v_d = 1'b0;   eoi_s_d = op_wdata[SRC_W-1:0];
    rd_v_d = 1'b0;    rd_d = {cppr_q, xisr_q, mfrr_q};

    if (op_valid) begin
      rej_b_v_d = req_valid;
      unique case (op_e)
        OP_ACCEPT: begin
          rd_v_d = 1'b1;
          irq_d = 1'b0; cppr_d = pprio_q; xisr_d = '0;
          pprio_d = PRIO_NONE; ipi_d = 1'b0;
        end
        OP_POLL: rd_v_d = 1'b1;
        OP_SET_PRIO: begin
          cppr_d = w_lo;
          if (w_lo < cppr_q) begin
            if (pend_busy && (w_lo <= pprio_q)) begin
              rej_a_v_d = !ipi_q;
              xisr_d = '0; pprio_d = PRIO_NONE; ipi_d = 1'b0; irq_d = 1'b0;
            end
          end else if (!pend_busy) begin
            resend_d = 1'b1;
            if (ipi_rs_wins) begin
              xisr_d = IPI_NUM; pprio_d = mfrr_q; ipi_d = 1'b1; irq_d = 1'b1;
            end
          end
        end
        OP_SET_IPI: begin
          mfrr_d = w_lo;
          if (ipi_wr_wins) begin
            rej_a_v_d = pend_busy && !ipi_q;
            xisr_d = IPI_NUM; pprio_d = w_lo; ipi_d = 1'b1; irq_d = 1'b1;
          end
        end
        OP_EOI: begin
          cppr_d = w_hi;
          eoi_v_d = 1'b1;
          if (!pend_busy) begin
            resend_d = 1'b1;
            if (ipi_rs_wins) begin
              xisr_d = IPI_NUM; pprio_d = mfrr_q; ipi_d = 1'b1; irq_d = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end else if (req_valid) begin
      if (req_wins) begin
        rej_a_v_d = pend_busy && !ipi_q;
        xisr_d = req_src; pprio_d = req_prio; ipi_d = 1'b0; irq_d = 1'b1;
      end else begin
        rej_b_v_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr_q <= '0; xisr_q <= '0; pprio_q <= PRIO_NONE; mfrr_q <= PRIO_NONE;
      ipi_q <= 1'b0; irq_q <= 1'b0; resend_q <= 1'b0;
    end else begin
      cppr_q <= cppr_d; xisr_q <= xisr_d; pprio_q <= pprio_d; mfrr_q <= mfrr_d;
      ipi_q <= ipi_d; irq_q <= irq_d; resend_q <= resend_d;
    end
  end

  ipr_strobe_reg #(.W(SRC_W)) u_rej_a (.clk(clk), .rst_n(rst_n),
    .v_d(rej_a_v_d), .data_d(rej_a_s_d), .v_q(rej_a_valid), .data_q(rej_a_src));
  ipr_strobe_reg #(.W(SRC_W)) u_rej_b (.clk(clk), .rst_n(rst_n),
    .v_d(rej_b_v_d), .data_d(rej_b_s_d), .v_q(rej_b_valid), .data_q(rej_b_src));
  ipr_strobe_reg #(.W(SRC_W)) u_eoi (.clk(clk), .rst_n(rst_n),
    .v_d(eoi_v_d), .data_d(eoi_s_d), .v_q(eoi_valid), .data_q(eoi_src));
  ipr_strobe_reg #(.W(RD_W)) u_rd (.clk(clk), .rst_n(rst_n),
    .v_d(rd_v_d), .data_d(rd_d), .v_q(rd_valid), .data_q(rd_q));

  assign rd_data    = rd_q[RD_W-1 -: REG_W];
  assign rd_ipi     = rd_q[PRIO_W-1:0];
  assign irq_out    = irq_q;
  assign resend_req = resend_q;
endmodule

// File: rtl/ipr_checker.sv
module ipr_checker
  import ipr_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [SRC_W-1:0]        req_src,
  input logic [PRIO_W-1:0]       req_prio,
  input logic                    op_valid,
  input logic [2:0]              op_code,
  input logic [SRC_W+PRIO_W-1:0] op_wdata,
  input logic [PRIO_W-1:0]       cppr_q,
  input logic                    irq_out,
  input logic                    rd_valid,
  input logic                    rej_a_valid,
  input logic [SRC_W-1:0]        rej_a_src,
  input logic                    rej_b_valid,
  input logic [SRC_W-1:0]        rej_b_src,
  input logic                    eoi_valid,
  input logic [SRC_W-1:0]        eoi_src,
  input logic                    resend_req
);
  // R3
  refuse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !op_valid && (req_prio >= cppr_q)
    |=> rej_b_valid && (rej_b_src == $past(req_src)));

  // R5
  accept_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_ACCEPT) |=> !irq_out && rd_valid);

  // R6
  poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_POLL)
    |=> $stable(irq_out) && rd_valid && !rej_a_valid && !resend_req && !eoi_valid);

  // R10
  eoi_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_EOI)
    |=> eoi_valid && (eoi_src == $past(op_wdata[SRC_W-1:0])));

  // R11
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op_valid |=> rej_b_valid && (rej_b_src == $past(req_src)));

  // R12
  no_ipi_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_a_valid |-> (rej_a_src != '0) && (rej_a_src != SRC_W'(IPI_SRC)));
endmodule

bind irq_presenter ipr_checker #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
  .req_prio(req_prio), .op_valid(op_valid), .op_code(op_code),
  .op_wdata(op_wdata), .cppr_q(cppr_q), .irq_out(irq_out),
  .rd_valid(rd_valid), .rej_a_valid(rej_a_valid), .rej_a_src(rej_a_src),
  .rej_b_valid(rej_b_valid), .rej_b_src(rej_b_src), .eoi_valid(eoi_valid),
  .eoi_src(eoi_src), .resend_req(resend_req));

// File: tb/tb_irq_presenter.sv
module tb_irq_presenter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [23:0] req_src;
  logic [7:0]  req_prio;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [31:0] op_wdata;
  logic        irq_out, rd_valid, rej_a_valid, rej_b_valid, eoi_valid, resend_req;
  logic [31:0] rd_data;
  logic [7:0]  rd_ipi;
  logic [23:0] rej_a_src, rej_b_src, eoi_src;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_presenter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
    .req_prio(req_prio), .op_valid(op_valid), .op_code(op_code),
    .op_wdata(op_wdata), .irq_out(irq_out), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ipi(rd_ipi), .rej_a_valid(rej_a_valid),
    .rej_a_src(rej_a_src), .rej_b_valid(rej_b_valid), .rej_b_src(rej_b_src),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req));

  // reference model state
  logic [7:0]  m_cppr, m_pprio, m_mfrr;
  logic [23:0] m_xisr;
  bit          m_ipi, m_irq;
  // expected strobes
  bit          e_ra, e_rb, e_eoi, e_rs, e_rd;
  logic [23:0] e_ras, e_rbs, e_eois;
  logic [31:0] e_rdd;
  logic [7:0]  e_rdi;
  string       m_tag;

  task automatic model_reset();
    m_cppr = 8'h00; m_xisr = 24'h0; m_pprio = 8'hFF; m_mfrr = 8'hFF;
    m_ipi = 1'b0; m_irq = 1'b0;
  endtask

  task automatic load_ipi(input logic [7:0] p);
    m_xisr = 24'd2; m_pprio = p; m_ipi = 1'b1; m_irq = 1'b1;
  endtask

  task automatic model_step(input bit ov, input logic [2:0] oc, input logic [31:0] wd,
                            input bit rv, input logic [23:0] rs, input logic [7:0] rp);
    bit busy;
    logic [7:0] np;
    busy = (m_xisr != 0);
    e_ra = 0; e_rb = 0; e_eoi = 0; e_rs = 0; e_rd = 0;
    e_ras = 0; e_rbs = 0; e_eois = 0; e_rdd = 0; e_rdi = 0;
    m_tag = "R1";
    if (ov) begin
      case (oc)
        3'd0: begin
          m_tag = "R5 R2"; e_rd = 1; e_rdd = {m_cppr, m_xisr}; e_rdi = m_mfrr;
          m_cppr = m_pprio; m_xisr = 0; m_pprio = 8'hFF; m_ipi = 0; m_irq = 0;
        end
        3'd1: begin
          m_tag = "R6 R2"; e_rd = 1; e_rdd = {m_cppr, m_xisr}; e_rdi = m_mfrr;
        end
        3'd2: begin
          np = wd[7:0];
          if (np < m_cppr) begin
            m_tag = "R7";
            if (busy && np <= m_pprio) begin
              if (!m_ipi) begin e_ra = 1; e_ras = m_xisr; end
              else m_tag = "R7 R12";
              m_xisr = 0; m_pprio = 8'hFF; m_ipi = 0; m_irq = 0;
            end
          end else begin
            m_tag = "R8";
            if (!busy) begin
              e_rs = 1;
              if (m_mfrr < np) load_ipi(m_mfrr);
            end
          end
          m_cppr = np;
        end
        3'd3: begin
          m_tag = "R9"; np = wd[7:0]; m_mfrr = np;
          if (np < m_cppr && !(busy && m_pprio <= np)) begin
            if (busy && !m_ipi) begin e_ra = 1; e_ras = m_xisr; end
            load_ipi(np);
          end
        end
        3'd4: begin
          m_tag = "R10"; m_cppr = wd[31:24]; e_eoi = 1; e_eois = wd[23:0];
          if (!busy) begin
            e_rs = 1;
            if (m_mfrr < m_cppr) load_ipi(m_mfrr);
          end
        end
        default: ;
      endcase
      if (rv) begin m_tag = "R11"; e_rb = 1; e_rbs = rs; end
    end else if (rv) begin
      if (rp >= m_cppr || (busy && m_pprio <= rp)) begin
        m_tag = "R3"; e_rb = 1; e_rbs = rs;
      end else begin
        m_tag = "R4";
        if (busy && !m_ipi) begin e_ra = 1; e_ras = m_xisr; end
        else if (busy) m_tag = "R4 R12";
        m_xisr = rs; m_pprio = rp; m_ipi = 0; m_irq = 1;
      end
    end
  endtask

  task automatic apply(input bit ov, input logic [2:0] oc, input logic [31:0] wd,
                       input bit rv, input logic [23:0] rs, input logic [7:0] rp);
    bit bad;
    op_valid = ov; op_code = oc; op_wdata = wd;
    req_valid = rv; req_src = rs; req_prio = rp;
    model_step(ov, oc, wd, rv, rs, rp);
    @(negedge clk);
    op_valid = 0; req_valid = 0;
    vectors++;
    bad = (irq_out !== m_irq) || (rej_a_valid !== e_ra) || (rej_b_valid !== e_rb) ||
          (eoi_valid !== e_eoi) || (resend_req !== e_rs) || (rd_valid !== e_rd) ||
          (e_ra && rej_a_src !== e_ras) || (e_rb && rej_b_src !== e_rbs) ||
          (e_eoi && eoi_src !== e_eois) ||
          (e_rd && (rd_data !== e_rdd || rd_ipi !== e_rdi));
    if (bad) begin
      fails++;
      $display("FAIL %s: got irq=%0b ra=%0b/%h rb=%0b/%h eoi=%0b/%h rs=%0b rd=%0b/%h/%h exp irq=%0b ra=%0b/%h rb=%0b/%h eoi=%0b/%h rs=%0b rd=%0b/%h/%h",
               m_tag, irq_out, rej_a_valid, rej_a_src, rej_b_valid, rej_b_src,
               eoi_valid, eoi_src, resend_req, rd_valid, rd_data, rd_ipi,
               m_irq, e_ra, e_ras, e_rb, e_rbs, e_eoi, e_eois, e_rs, e_rd, e_rdd, e_rdi);
    end
  endtask

  function automatic logic [7:0] pick_prio();
    int r = $urandom_range(0, 9);
    return (r == 9) ? 8'hFF : 8'(r);
  endfunction

  initial begin
    void'($urandom(32'd1357));
    rst_n = 0; op_valid = 0; req_valid = 0; op_code = 0; op_wdata = 0;
    req_src = 0; req_prio = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle after reset, then poll shows word 0 and IPI priority FF (R2 R6)
    apply(0, 0, 0, 0, 0, 0);
    apply(1, 3'd1, 0, 0, 0, 0);
    apply(1, 3'd2, 32'hFF, 0, 0, 0);          // R8: empty slot -> resend
    apply(0, 0, 0, 1, 24'd5, 8'd4);           // R4 admit
    apply(0, 0, 0, 1, 24'd6, 8'd4);           // R3 equal pending
    apply(0, 0, 0, 1, 24'd7, 8'd2);           // R4 displace 5
    apply(1, 3'd3, 32'h1, 0, 0, 0);           // R9 IPI displaces 7
    apply(0, 0, 0, 1, 24'd8, 8'd0);           // R12 IPI displaced silently
    apply(1, 3'd0, 0, 0, 0, 0);               // R5 accept
    apply(0, 0, 0, 1, 24'd9, 8'd0);           // R3 not below cpu priority
    apply(1, 3'd4, 32'hFF00_0008, 0, 0, 0);   // R10 eoi reloads IPI
    apply(1, 3'd0, 0, 0, 0, 0);               // R5 accept IPI
    apply(1, 3'd2, 32'h0, 0, 0, 0);           // R7 more favoured, empty
    apply(1, 3'd2, 32'hFF, 0, 0, 0);          // R8 resend + IPI
    apply(1, 3'd2, 32'h1, 0, 0, 0);           // R7 clear IPI, R12 no reject
    apply(1, 3'd1, 0, 1, 24'd10, 8'd0);       // R11 collision
    apply(1, 3'd2, 32'hFF, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      bit ov = ($urandom_range(0, 9) < 4);
      bit rv = ($urandom_range(0, 9) < 6);
      logic [2:0] oc = 3'($urandom_range(0, 4));
      logic [31:0] wd = {pick_prio(), 24'($urandom_range(3, 60))};
      if (oc == 3'd2 || oc == 3'd3) wd = {24'h0, pick_prio()};
      apply(ov, oc, wd, rv, 24'($urandom_range(3, 60)), pick_prio());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule